// File: doc/BRIEF.md
# Multi-Source Event Interrupt Aggregator

This block collects single-cycle event strobes from a four-port power-sourcing controller and holds each one as a sticky bit in a small bank of event registers. The event sources are power-enable changes, power-good changes, detection done, classification done, overcurrent cut, disconnect, startup timeout, current-limit violation and supply faults. An 8-bit read-only summary register ORs each group of event bits into one flag. The summary register, a mask register and a global enable decide the active-low interrupt pin.

The pin is modelled as a registered level plus a separate output-enable. When the global enable is cleared, the output-enable drops and the pin floats. Software reaches the registers through a simple synchronous port: a write strobe with address and data, and a read path that is combinational from the address. A single command bit clears every event register at once. An event that arrives in the same cycle as that command is kept.

Top module: `irq_agg_top`

## Requirements
- R1: A strobe on any event input sets its bit in the event register in the next clock edge. The bit stays set, with no further strobe, until a clear-all command. The register layout is: address 2h holds power-enable change in bits 3:0 and power-good change in bits 7:4. Address 3h holds detection done in 3:0 and classification done in 7:4. Address 4h holds overcurrent cut in 3:0 and disconnect in 7:4. Address 5h holds startup timeout in 3:0 and current-limit violation in 7:4. Address 6h holds supply faults in 7:4, with bits 3:0 reading 0. Port n maps to the bit at offset n in each field.
- R2: The summary register at address 0h reads, from bit 7 down to bit 0: supply fault, startup timeout, overcurrent (cut OR current-limit violation), classification done, detection done, disconnect, power-good change, power-enable change. Each bit is the OR of its group's four port bits.
- R3: After reset, the summary, event and mask registers read 00h, the control register at address 7h reads 80h, the interrupt level is 1 and the output-enable is 1.
- R4: The interrupt level goes to 0 one clock after any summary bit is 1 while the matching bit of the mask register (address 1h) is 0. It returns to 1 one clock after no such bit remains. Setting a mask bit suppresses its source.
- R5: Writing a value with bit 7 set to the command address 8h clears every event register and the summary register. A write to address 8h with bit 7 clear has no effect. Address 8h reads 00h.
- R6: An event strobe in the same cycle as a clear-all command leaves its own bit set after the clear.
- R7: Bit 7 of the control register is the global enable and is read/write. The output-enable follows it one clock later, so writing 00h releases the pin.
- R8: Writes to the summary register and to the event registers are ignored. The mask register reads back what was written.
- R9: Reads of addresses 9h to Fh return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pe_i | input | 4 | Per-port power-enable change strobes |
| ev_pg_i | input | 4 | Per-port power-good change strobes |
| ev_det_i | input | 4 | Per-port detection-done strobes |
| ev_cls_i | input | 4 | Per-port classification-done strobes |
| ev_cut_i | input | 4 | Per-port overcurrent cut strobes |
| ev_dis_i | input | 4 | Per-port disconnect strobes |
| ev_tst_i | input | 4 | Per-port startup-timeout strobes |
| ev_icv_i | input | 4 | Per-port current-limit-violation strobes |
| ev_sup_i | input | 4 | Supply fault strobes |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| int_n_o | output | 1 | Registered active-low interrupt level |
| int_oe_o | output | 1 | Registered output-enable of the interrupt pin |

## Verification
The bench drives each of the 36 event lines alone, one at a time. Every read then shows exactly one event bit and one summary bit. A wrong field position, a wrong port offset or a crossed summary wire each shows up as a distinct mismatch. The overcurrent bit is driven from both of its registers, which separates the merged source from the others.

For every line, the bench then applies the source's own mask bit and the complement of that mask. These two settings tell a correct mask apart from one that is shifted or inverted. Separate patterns cover the following cases:
- a clear-all command coinciding with a strobe
- a command write with bit 7 clear
- writes aimed at the read-only registers
- toggling of the global enable

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int unsigned REG_AW = 4;

   typedef enum logic [REG_AW-1:0] {
      ADR_SUM  = 4'h0,
      ADR_MASK = 4'h1,
      ADR_PWR  = 4'h2,
      ADR_DET  = 4'h3,
      ADR_FLT  = 4'h4,
      ADR_STU  = 4'h5,
      ADR_SUP  = 4'h6,
      ADR_CTL  = 4'h7,
      ADR_CMD  = 4'h8
   } reg_addr_e;

   // summary bit positions (fixed order)
   localparam int unsigned SB_PE  = 0;
   localparam int unsigned SB_PG  = 1;
   localparam int unsigned SB_DIS = 2;
   localparam int unsigned SB_DET = 3;
   localparam int unsigned SB_CLS = 4;
   localparam int unsigned SB_OC  = 5;
   localparam int unsigned SB_TST = 6;
   localparam int unsigned SB_SUP = 7;

   localparam int unsigned NUM_PAIR_REGS = 4;
   localparam int unsigned CTL_BIT = 7;
endpackage

// File: rtl/irq_event_bank.sv
module irq_event_bank #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("irq_event_bank: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= (clr_i ? '0 : q_r) | set_i;
   end

   assign q_o = q_r;

   // R1
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((q_o & $past(q_o)) == $past(q_o)));

   // R6
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

   // R5
   clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !(|set_i)) |=> (q_o == '0));
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
   parameter int unsigned NPORT = 4,
   parameter int unsigned SW    = 8,
   localparam int unsigned PW   = 2 * NPORT
) (
   input  logic [PW-1:0]    pwr_i,
   input  logic [PW-1:0]    det_i,
   input  logic [PW-1:0]    flt_i,
   input  logic [PW-1:0]    stu_i,
   input  logic [NPORT-1:0] sup_i,
   output logic [SW-1:0]    sum_o
);
   import irq_agg_pkg::*;

   generate
      if (SW != 8) begin : g_bad_sw
         $error("irq_summary: summary width must be 8");
      end
   endgenerate

   always_comb begin
      sum_o         = '0;
      sum_o[SB_PE]  = |pwr_i[NPORT-1:0];
      sum_o[SB_PG]  = |pwr_i[PW-1:NPORT];
      sum_o[SB_DET] = |det_i[NPORT-1:0];
      sum_o[SB_CLS] = |det_i[PW-1:NPORT];
      sum_o[SB_DIS] = |flt_i[PW-1:NPORT];
      sum_o[SB_OC]  = (|flt_i[NPORT-1:0]) | (|stu_i[PW-1:NPORT]);
      sum_o[SB_TST] = |stu_i[NPORT-1:0];
      sum_o[SB_SUP] = |sup_i;
   end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
   parameter int unsigned SW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [SW-1:0] sum_i,
   input  logic [SW-1:0] mask_i,
   input  logic          en_i,
   output logic          int_n_o,
   output logic          oe_o
);
   logic pend;
   assign pend = |(sum_i & ~mask_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_n_o <= 1'b1;
         oe_o    <= 1'b1;
      end else begin
         int_n_o <= ~pend;
         oe_o    <= en_i;
      end
   end

   // R4
   assert_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sum_i & ~mask_i)) |=> !int_n_o);

   // R4
   release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(sum_i & ~mask_i)) |=> int_n_o);

   // R7
   float_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !oe_o);
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top #(
   parameter int unsigned NPORT = 4,
   parameter int unsigned DW    = 8,
   parameter int unsigned AW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPORT-1:0] ev_pe_i,
   input  logic [NPORT-1:0] ev_pg_i,
   input  logic [NPORT-1:0] ev_det_i,
   input  logic [NPORT-1:0] ev_cls_i,
   input  logic [NPORT-1:0] ev_cut_i,
   input  logic [NPORT-1:0] ev_dis_i,
   input  logic [NPORT-1:0] ev_tst_i,
   input  logic [NPORT-1:0] ev_icv_i,
   input  logic [NPORT-1:0] ev_sup_i,
   input  logic             wr_en_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [DW-1:0]    wdata_i,
   output logic [DW-1:0]    rdata_o,
   output logic             int_n_o,
   output logic             int_oe_o
);
   import irq_agg_pkg::*;

   localparam int unsigned PW = 2 * NPORT;
   localparam int unsigned NR = NUM_PAIR_REGS;

   generate
      if (DW != PW)       begin : g_bad_dw $error("irq_agg_top: DW must equal 2*NPORT"); end
      if (DW != 8)        begin : g_bad_sw $error("irq_agg_top: DW must be 8"); end
      if (AW != REG_AW)   begin : g_bad_aw $error("irq_agg_top: AW must match the map"); end
   endgenerate

   logic [PW-1:0]    pair_set [NR];
   logic [PW-1:0]    pair_q   [NR];
   logic [NPORT-1:0] sup_q;
   logic [DW-1:0]    sum;
   logic [DW-1:0]    mask_q;
   logic             en_q;
   logic             clr_all;
   logic             any_set;

   assign pair_set[0] = {ev_pg_i,  ev_pe_i};
   assign pair_set[1] = {ev_cls_i, ev_det_i};
   assign pair_set[2] = {ev_dis_i, ev_cut_i};
   assign pair_set[3] = {ev_icv_i, ev_tst_i};

   assign clr_all = wr_en_i && (addr_i == AW'(ADR_CMD)) && wdata_i[CTL_BIT];
   assign any_set = (|ev_pe_i) | (|ev_pg_i) | (|ev_det_i) | (|ev_cls_i) | (|ev_cut_i)
                  | (|ev_dis_i) | (|ev_tst_i) | (|ev_icv_i) | (|ev_sup_i);

   genvar k;
   generate
      for (k = 0; k < NR; k++) begin : g_pair
         irq_event_bank #(.W(PW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (pair_set[k]),
            .clr_i (clr_all),
            .q_o   (pair_q[k])
         );
      end
   endgenerate

   irq_event_bank #(.W(NPORT)) u_sup_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ev_sup_i),
      .clr_i (clr_all),
      .q_o   (sup_q)
   );

   irq_summary #(.NPORT(NPORT), .SW(DW)) u_sum (
      .pwr_i (pair_q[0]),
      .det_i (pair_q[1]),
      .flt_i (pair_q[2]),
      .stu_i (pair_q[3]),
      .sup_i (sup_q),
      .sum_o (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         en_q   <= 1'b1;
      end else if (wr_en_i) begin
         if (addr_i == AW'(ADR_MASK)) mask_q <= wdata_i;
         if (addr_i == AW'(ADR_CTL))  en_q   <= wdata_i[CTL_BIT];
      end
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         AW'(ADR_SUM):  rdata_o = sum;
         AW'(ADR_MASK): rdata_o = mask_q;
         AW'(ADR_PWR):  rdata_o = pair_q[0];
         AW'(ADR_DET):  rdata_o = pair_q[1];
         AW'(ADR_FLT):  rdata_o = pair_q[2];
         AW'(ADR_STU):  rdata_o = pair_q[3];
         AW'(ADR_SUP):  rdata_o = {sup_q, {(DW-NPORT){1'b0}}};
         AW'(ADR_CTL):  rdata_o[CTL_BIT] = en_q;
         default:       rdata_o = '0;
      endcase
   end

   irq_pin_drv #(.SW(DW)) u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .sum_i   (sum),
      .mask_i  (mask_q),
      .en_i    (en_q),
      .int_n_o (int_n_o),
      .oe_o    (int_oe_o)
   );

   // R8
   sum_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && (addr_i == AW'(ADR_SUM)) && !any_set) |=> $stable(sum));

   // R8
   mask_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && (addr_i == AW'(ADR_MASK))) |=> (mask_q == $past(wdata_i)));
endmodule

// File: tb/irq_agg_top_bench.sv
module irq_agg_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ev_pe = '0, ev_pg = '0, ev_det = '0, ev_cls = '0, ev_cut = '0;
   logic [3:0] ev_dis = '0, ev_tst = '0, ev_icv = '0, ev_sup = '0;
   logic       wr_en = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       int_n, int_oe;
   int         checks = 0;
   int         errors = 0;
   bit         done = 0;

   always #10 clk = ~clk;

   irq_agg_top u_irq_agg_top (
      .clk(clk), .rst_n(rst_n),
      .ev_pe_i(ev_pe), .ev_pg_i(ev_pg), .ev_det_i(ev_det), .ev_cls_i(ev_cls),
      .ev_cut_i(ev_cut), .ev_dis_i(ev_dis), .ev_tst_i(ev_tst), .ev_icv_i(ev_icv),
      .ev_sup_i(ev_sup), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .int_n_o(int_n), .int_oe_o(int_oe)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic set_line(input int g, input int p, input logic v);
      case (g)
         0: ev_pe[p]  = v;
         1: ev_pg[p]  = v;
         2: ev_det[p] = v;
         3: ev_cls[p] = v;
         4: ev_cut[p] = v;
         5: ev_dis[p] = v;
         6: ev_tst[p] = v;
         7: ev_icv[p] = v;
         default: ev_sup[p] = v;
      endcase
   endtask

   task automatic pulse(input int g, input int p);
      @(negedge clk);
      set_line(g, p, 1'b1);
      @(negedge clk);
      set_line(g, p, 1'b0);
   endtask

   function automatic int reg_of(input int g);
      return (g == 8) ? 6 : 2 + g / 2;
   endfunction

   function automatic int bit_of(input int g, input int p);
      return (g == 8) ? 4 + p : (g % 2) * 4 + p;
   endfunction

   function automatic int sbit_of(input int g);
      case (g)
         0: return 0;
         1: return 1;
         2: return 3;
         3: return 4;
         4: return 5;
         5: return 2;
         6: return 6;
         7: return 5;
         default: return 7;
      endcase
   endfunction

   task automatic chk_events(input string tag, input int ea, input logic [7:0] ev);
      logic [7:0] v;
      for (int a = 2; a <= 6; a++) begin
         rd(a[3:0], v);
         chk(tag, v, (a == ea) ? ev : 8'h00);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R3 / R9: reset values and unmapped reads
      for (int a = 0; a < 16; a++) begin
         rd(a[3:0], v);
         chk((a == 7) ? "R3 ctl" : (a >= 9) ? "R9 unmapped" : "R3 reg", v, (a == 7) ? 8'h80 : 8'h00);
      end
      chk("R3 int_n", {7'b0, int_n}, 8'h01);
      chk("R3 oe", {7'b0, int_oe}, 8'h01);

      // R1 R2 R4 R5: sweep every event line
      for (int g = 0; g < 9; g++) begin
         for (int p = 0; p < 4; p++) begin
            logic [7:0] sb;
            sb = 8'h01 << sbit_of(g);
            pulse(g, p);
            chk("R4 registered", {7'b0, int_n}, 8'h01);
            tick();
            chk("R4 low", {7'b0, int_n}, 8'h00);
            chk_events("R1 set", reg_of(g), 8'h01 << bit_of(g, p));
            rd(4'h0, v);
            chk("R2 summary", v, sb);
            repeat (3) tick();
            chk_events("R1 sticky", reg_of(g), 8'h01 << bit_of(g, p));
            wr(4'h1, sb);
            tick();
            chk("R4 masked", {7'b0, int_n}, 8'h01);
            wr(4'h1, ~sb);
            tick();
            chk("R4 other mask", {7'b0, int_n}, 8'h00);
            wr(4'h1, 8'h00);
            wr(4'h8, 8'h80);
            chk_events("R5 clear", 0, 8'h00);
            rd(4'h0, v);
            chk("R5 summary clear", v, 8'h00);
            tick();
            chk("R4 release", {7'b0, int_n}, 8'h01);
         end
      end

      // R5: command with bit 7 clear has no effect, reads 00
      pulse(2, 1);
      wr(4'h8, 8'h7F);
      rd(4'h3, v);
      chk("R5 no clear", v, 8'h02);
      rd(4'h8, v);
      chk("R5 cmd read", v, 8'h00);

      // R8: writes to summary and event registers ignored
      wr(4'h0, 8'hFF);
      wr(4'h3, 8'h00);
      wr(4'h5, 8'hFF);
      rd(4'h0, v);
      chk("R8 summary ro", v, 8'h08);
      rd(4'h3, v);
      chk("R8 event ro", v, 8'h02);
      rd(4'h5, v);
      chk("R8 event ro", v, 8'h00);
      wr(4'h1, 8'hA5);
      rd(4'h1, v);
      chk("R8 mask rw", v, 8'hA5);
      wr(4'h1, 8'h00);

      // R6: strobe coinciding with clear-all survives
      @(negedge clk);
      wr_en = 1'b1; addr = 4'h8; wdata = 8'h80; ev_pe[2] = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0; ev_pe[2] = 1'b0;
      chk_events("R6 event wins", 2, 8'h04);
      rd(4'h0, v);
      chk("R6 summary", v, 8'h01);

      // R7: global enable releases pin
      wr(4'h7, 8'h00);
      chk("R7 oe still", {7'b0, int_oe}, 8'h01);
      tick();
      chk("R7 oe off", {7'b0, int_oe}, 8'h00);
      rd(4'h7, v);
      chk("R7 ctl read", v, 8'h00);
      wr(4'h7, 8'h80);
      tick();
      chk("R7 oe on", {7'b0, int_oe}, 8'h01);
      wr(4'h8, 8'h80);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule